// File: doc/BRIEF.md
# Segmented Issue-Queue Entry Allocator

This block hands out free issue-queue entries to the instructions dispatched in one cycle. The queue's entries are split into equal segments, and each dispatch slot k is served by segment k alone. Each segment runs its own small search over its slice of an entry-availability vector. It can place at most one instruction per cycle, and it takes the lowest-numbered free entry it holds. A full segment therefore stalls its slot, even when free entries exist in other segments. That loss of packing is the price of replacing one wide many-of-N search with several narrow one-of-D searches.

Placement stays in program order. If slot k cannot be placed, slot k and every later slot are refused in that cycle, and the dispatcher resends them. Entries leave the queue in any order: a per-entry deallocate pulse marks an entry free again from the next cycle on. A granted entry is marked busy from the next cycle on. Grants are combinational from the registered availability vector, so an entry freed in the current cycle is offered no earlier than the following one.

Top module: `segq_entry_alloc`

## Requirements
- R1: After reset every entry is free (`avail_vec` all ones), and the first request of four gets entries 0, 4, 8 and 12.
- R2: Slot k is only ever granted an entry of segment k, that is an index from k*SEG_DEPTH to k*SEG_DEPTH+SEG_DEPTH-1.
- R3: A granted entry is free in `avail_vec` in that cycle, and it is the lowest-indexed free entry of its segment.
- R4: Slots 0 to `disp_count`-1 request. A slot is granted only if it requests, its segment has a free entry, and every lower slot is granted in the same cycle.
- R5: When segment k has no free entry, slot k and all higher slots get no grant, even if other segments have free entries.
- R6: `accept_cnt` equals the number of set bits of `grant_vld` in the same cycle.
- R7: An entry granted in a cycle reads as busy (bit 0 in `avail_vec`) from the next cycle, unless it is also deallocated in that cycle.
- R8: A deallocate pulse on bit e of `rel_vec` makes entry e read as free from the next cycle.
- R9: An entry that is busy and deallocated in the same cycle is not granted in that cycle. It can be granted from the next cycle.
- R10: A `disp_count` above NUM_SEG behaves exactly like NUM_SEG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; marks all entries free |
| disp_count | input | CNT_W (3) | Number of instructions offered this cycle, in slots 0 upward |
| rel_vec | input | NUM_ENT (16) | One deallocate pulse per entry |
| grant_vld | output | NUM_SEG (4) | Slot k received an entry this cycle |
| grant_idx | output | NUM_SEG*IDX_W (16) | Entry index for slot k at bits k*IDX_W upward |
| accept_cnt | output | CNT_W (3) | Number of slots granted this cycle |
| avail_vec | output | NUM_ENT (16) | Registered availability, 1 = free |

## Verification
A corrupted availability bit appears on `avail_vec` one edge after the event that caused it. In the same cycle it also moves a segment's pick to a different index on `grant_idx`, or it grants a busy entry. A fault in the in-order gate shows in the same cycle as a grant above a refused slot, or as a count that disagrees with `grant_vld`. The vector walk drives segments into empty, partly free and simultaneously freed states, so each such fault surfaces in the row that creates it or in the next row.

// File: rtl/segq_pkg.sv
package segq_pkg;
   // bit width able to hold 0..n-1, never below one
   function automatic int unsigned segq_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   // true when n is a power of two
   function automatic bit segq_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/segq_seg_pick.sv
// One-of-DEPTH search: lowest-indexed set bit of the segment's free slice.
module segq_seg_pick #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned LW    = 2
) (
   input  logic [DEPTH-1:0] free_i,
   output logic             found_o,
   output logic [LW-1:0]    pick_o
);
   generate
      if (DEPTH < 2) begin : g_bad
         $error("segq_seg_pick: DEPTH must be at least 2");
      end
      if (LW < $clog2(DEPTH)) begin : g_bad_lw
         $error("segq_seg_pick: LW too narrow for DEPTH");
      end
   endgenerate

   always_comb begin
      found_o = 1'b0;
      pick_o  = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (free_i[i]) begin
            found_o = 1'b1;
            pick_o  = LW'(i);
         end
      end
   end
endmodule

// File: rtl/segq_order_gate.sv
// Keeps placement in program order: a slot is taken only when it requests,
// its segment has room, and every lower slot is taken too.
module segq_order_gate #(
   parameter int unsigned N  = 4,
   parameter int unsigned CW = 3
) (
   input  logic [CW-1:0] count_i,
   input  logic [N-1:0]  room_i,
   output logic [N-1:0]  take_o,
   output logic [CW-1:0] taken_o
);
   logic [N-1:0] want;

   generate
      if ((1 << CW) <= N) begin : g_bad
         $error("segq_order_gate: CW cannot represent N");
      end
      for (genvar k = 0; k < N; k++) begin : g_slot
         localparam logic [CW-1:0] KV = CW'(k);
         assign want[k] = (count_i > KV);
         if (k == 0) begin : g_first
            assign take_o[k] = want[k] & room_i[k];
         end else begin : g_next
            assign take_o[k] = want[k] & room_i[k] & take_o[k-1];
         end
      end
   endgenerate

   always_comb begin
      taken_o = '0;
      for (int i = 0; i < N; i++) begin
         taken_o = taken_o + CW'(take_o[i]);
      end
   end
endmodule

// File: rtl/segq_avail_reg.sv
// Availability state: cleared on allocation, set on deallocation (set wins).
module segq_avail_reg #(
   parameter int unsigned N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] clr_i,
   input  logic [N-1:0] set_i,
   output logic [N-1:0] avail_o
);
   logic [N-1:0] avail_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         avail_q <= '1;
      end else begin
         avail_q <= (avail_q & ~clr_i) | set_i;
      end
   end

   assign avail_o = avail_q;
endmodule

// File: rtl/segq_entry_alloc.sv
module segq_entry_alloc #(
   parameter int unsigned NUM_SEG   = 4,
   parameter int unsigned SEG_DEPTH = 4,
   localparam int unsigned NUM_ENT  = NUM_SEG * SEG_DEPTH,
   localparam int unsigned IDX_W    = segq_pkg::segq_bits(NUM_ENT),
   localparam int unsigned CNT_W    = segq_pkg::segq_bits(NUM_SEG + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [CNT_W-1:0]         disp_count,
   input  logic [NUM_ENT-1:0]       rel_vec,
   output logic [NUM_SEG-1:0]       grant_vld,
   output logic [NUM_SEG*IDX_W-1:0] grant_idx,
   output logic [CNT_W-1:0]         accept_cnt,
   output logic [NUM_ENT-1:0]       avail_vec
);
   localparam int unsigned LOC_W = segq_pkg::segq_bits(SEG_DEPTH);

   generate
      if (NUM_SEG < 1) begin : g_bad_seg
         $error("segq_entry_alloc: NUM_SEG must be at least 1");
      end
      if (SEG_DEPTH < 2) begin : g_bad_depth
         $error("segq_entry_alloc: SEG_DEPTH must be at least 2");
      end
      if (NUM_ENT > 4096) begin : g_bad_size
         $error("segq_entry_alloc: queue too large");
      end
   endgenerate

   logic [NUM_SEG-1:0] seg_room;
   logic [NUM_SEG-1:0] seg_take;
   logic [NUM_ENT-1:0] alloc_clr;
   logic [NUM_ENT-1:0] avail_q;

   segq_avail_reg #(.N(NUM_ENT)) u_avail (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (alloc_clr),
      .set_i   (rel_vec),
      .avail_o (avail_q)
   );

   segq_order_gate #(.N(NUM_SEG), .CW(CNT_W)) u_order (
      .count_i (disp_count),
      .room_i  (seg_room),
      .take_o  (seg_take),
      .taken_o (accept_cnt)
   );

   generate
      for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
         localparam logic [IDX_W-1:0] BASE = IDX_W'(s * SEG_DEPTH);
         logic [LOC_W-1:0] loc;
         logic [IDX_W-1:0] full_idx;

         segq_seg_pick #(.DEPTH(SEG_DEPTH), .LW(LOC_W)) u_pick (
            .free_i  (avail_q[s*SEG_DEPTH +: SEG_DEPTH]),
            .found_o (seg_room[s]),
            .pick_o  (loc)
         );

         // index composition: OR when segments are aligned, add otherwise
         if (segq_pkg::segq_pow2(SEG_DEPTH)) begin : g_aligned
            assign full_idx = BASE | IDX_W'(loc);
         end else begin : g_packed
            assign full_idx = BASE + IDX_W'(loc);
         end

         assign grant_idx[s*IDX_W +: IDX_W] = full_idx;

         for (genvar j = 0; j < SEG_DEPTH; j++) begin : g_bit
            localparam logic [LOC_W-1:0] JV = LOC_W'(j);
            assign alloc_clr[s*SEG_DEPTH + j] = seg_take[s] && (loc == JV);
         end
      end
   endgenerate

   assign grant_vld = seg_take;
   assign avail_vec = avail_q;
endmodule

// File: rtl/segq_alloc_chk.sv
module segq_alloc_chk #(
   parameter int unsigned NUM_SEG   = 4,
   parameter int unsigned SEG_DEPTH = 4,
   localparam int unsigned NUM_ENT  = NUM_SEG * SEG_DEPTH,
   localparam int unsigned IDX_W    = segq_pkg::segq_bits(NUM_ENT),
   localparam int unsigned CNT_W    = segq_pkg::segq_bits(NUM_SEG + 1)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [CNT_W-1:0]         disp_count,
   input logic [NUM_ENT-1:0]       rel_vec,
   input logic [NUM_SEG-1:0]       grant_vld,
   input logic [NUM_SEG*IDX_W-1:0] grant_idx,
   input logic [CNT_W-1:0]         accept_cnt,
   input logic [NUM_ENT-1:0]       avail_vec
);
   logic [NUM_ENT-1:0] hit;

   always_comb begin
      hit = '0;
      for (int e = 0; e < NUM_ENT; e++) begin
         for (int k = 0; k < NUM_SEG; k++) begin
            if (grant_vld[k] && (grant_idx[k*IDX_W +: IDX_W] == IDX_W'(e))) begin
               hit[e] = 1'b1;
            end
         end
      end
   end

   // R6: count agrees with grant flags
   p_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      accept_cnt == CNT_W'($countones(grant_vld)));

   generate
      for (genvar k = 0; k < NUM_SEG; k++) begin : g_slot
         localparam logic [IDX_W:0] LO = (IDX_W+1)'(k * SEG_DEPTH);
         localparam logic [IDX_W:0] HI = (IDX_W+1)'((k + 1) * SEG_DEPTH);
         // R2: slot stays in its own segment
         p_seg_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
            grant_vld[k] |-> (({1'b0, grant_idx[k*IDX_W +: IDX_W]} >= LO) &&
                              ({1'b0, grant_idx[k*IDX_W +: IDX_W]} <  HI)));
         // R3: only a free entry is handed out
         p_grant_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
            grant_vld[k] |-> avail_vec[grant_idx[k*IDX_W +: IDX_W]]);
         if (k > 0) begin : g_ord
            // R4: no grant above a refused slot
            p_inorder_r4: assert property (@(posedge clk) disable iff (!rst_n)
               grant_vld[k] |-> grant_vld[k-1]);
         end
      end
      for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
         // R7: granted entry becomes busy
         p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[e] && !rel_vec[e]) |=> !avail_vec[e]);
         // R8: deallocated entry becomes free
         p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
            rel_vec[e] |=> avail_vec[e]);
         // R9: entry freed this cycle is not offered this cycle
         p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (rel_vec[e] && !avail_vec[e]) |-> !hit[e]);
      end
   endgenerate
endmodule

bind segq_entry_alloc segq_alloc_chk #(
   .NUM_SEG   (NUM_SEG),
   .SEG_DEPTH (SEG_DEPTH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .disp_count (disp_count),
   .rel_vec    (rel_vec),
   .grant_vld  (grant_vld),
   .grant_idx  (grant_idx),
   .accept_cnt (accept_cnt),
   .avail_vec  (avail_vec)
);

// File: tb/segq_entry_alloc_test.sv
module segq_entry_alloc_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  disp_count = '0;
   logic [15:0] rel_vec = '0;
   logic [3:0]  grant_vld;
   logic [15:0] grant_idx;
   logic [2:0]  accept_cnt;
   logic [15:0] avail_vec;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   segq_entry_alloc uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .disp_count (disp_count),
      .rel_vec    (rel_vec),
      .grant_vld  (grant_vld),
      .grant_idx  (grant_idx),
      .accept_cnt (accept_cnt),
      .avail_vec  (avail_vec)
   );

   typedef struct packed {
      logic [2:0]  cnt;
      logic [15:0] rel;
      logic [3:0]  vld;
      logic [15:0] idx;   // slot k at bits 4k+3..4k, compared when valid
      logic [2:0]  acc;
      logic [15:0] av;    // availability after the edge
   } row_t;

   // Segments: 0..3, 4..7, 8..11, 12..15. Walk starts from reset state.
   localparam row_t TBL [11] = '{
      '{3'd4, 16'h0000, 4'b1111, 16'hC840, 3'd4, 16'hEEEE},  // R1 R3 first picks
      '{3'd4, 16'h0000, 4'b1111, 16'hD951, 3'd4, 16'hCCCC},  // R3 next lowest
      '{3'd2, 16'h0000, 4'b0011, 16'h0062, 3'd2, 16'hCC88},  // R4 partial request
      '{3'd4, 16'h0001, 4'b1111, 16'hEA73, 3'd4, 16'h8801},  // R9 freed 0 not offered
      '{3'd4, 16'h0000, 4'b0001, 16'h0000, 3'd1, 16'h8800},  // R5 seg1 full stalls 1..3
      '{3'd1, 16'h00F0, 4'b0000, 16'h0000, 3'd0, 16'h88F0},  // R5 seg0 full, R8 release
      '{3'd7, 16'h0000, 4'b0000, 16'h0000, 3'd0, 16'h88F0},  // R4 slot0 refused
      '{3'd0, 16'h000F, 4'b0000, 16'h0000, 3'd0, 16'h88FF},  // R8 release seg0
      '{3'd7, 16'h0000, 4'b1111, 16'hFB40, 3'd4, 16'h00EE},  // R10 clamp to 4
      '{3'd3, 16'h0000, 4'b0011, 16'h0051, 3'd2, 16'h00CC},  // R5 seg2 empty
      '{3'd4, 16'hFFFF, 4'b0011, 16'h0062, 3'd2, 16'hFFFF}   // R7 R8 release wins
   };

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      #(20 * 5000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(avail_vec == 16'hFFFF, "R1 avail after reset", 32'(avail_vec), 32'hFFFF);
      chk(grant_vld == 4'b0000, "R1 no grant at count 0", 32'(grant_vld), 32'h0);
      chk(accept_cnt == 3'd0, "R6 count at reset", 32'(accept_cnt), 32'h0);
      rst_n = 1'b1;

      for (int r = 0; r < 11; r++) begin
         @(negedge clk);
         disp_count = TBL[r].cnt;
         rel_vec    = TBL[r].rel;
         #2;
         chk(grant_vld == TBL[r].vld, $sformatf("R4 R5 grant_vld row %0d", r),
             32'(grant_vld), 32'(TBL[r].vld));
         chk(accept_cnt == TBL[r].acc, $sformatf("R6 accept_cnt row %0d", r),
             32'(accept_cnt), 32'(TBL[r].acc));
         for (int k = 0; k < 4; k++) begin
            if (TBL[r].vld[k]) begin
               chk(grant_idx[k*4 +: 4] == TBL[r].idx[k*4 +: 4],
                   $sformatf("R2 R3 idx row %0d slot %0d", r, k),
                   32'(grant_idx[k*4 +: 4]), 32'(TBL[r].idx[k*4 +: 4]));
            end
         end
         @(posedge clk);
         #2;
         chk(avail_vec == TBL[r].av, $sformatf("R7 R8 avail row %0d", r),
             32'(avail_vec), 32'(TBL[r].av));
      end

      // R1: reset in mid-operation restores all entries
      @(negedge clk);
      disp_count = 3'd4;
      rel_vec    = 16'h0000;
      @(posedge clk);
      @(negedge clk);
      disp_count = 3'd0;
      chk(avail_vec == 16'hEEEE, "R7 busy before reset", 32'(avail_vec), 32'hEEEE);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(avail_vec == 16'hFFFF, "R1 avail after mid reset", 32'(avail_vec), 32'hFFFF);
      rst_n = 1'b1;
      disp_count = 3'd4;
      #2;
      chk(grant_idx == 16'hC840, "R1 picks after reset", 32'(grant_idx), 32'hC840);

      // R9: busy entry 0 freed while requested is offered only a cycle later
      @(posedge clk);
      @(negedge clk);
      disp_count = 3'd0;
      @(posedge clk);
      @(negedge clk);
      disp_count = 3'd1;
      rel_vec    = 16'h0001;
      #2;
      chk(grant_idx[3:0] == 4'd1, "R9 freed entry skipped", 32'(grant_idx[3:0]), 32'h1);
      @(posedge clk);
      @(negedge clk);
      rel_vec = 16'h0000;
      #2;
      chk(grant_vld[0] && grant_idx[3:0] == 4'd0, "R9 freed entry offered next",
          32'(grant_idx[3:0]), 32'h0);
      @(posedge clk);
      @(negedge clk);
      disp_count = 3'd0;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule